// File: doc/BRIEF.md
# Calendar Timekeeping Register File

This block keeps wall-clock time and date in seven byte-wide fields (seconds, minutes, hours, day of week, day of month, month and a two-digit year). A one-cycle strobe arriving once per second advances the fields. The carry chain follows month lengths and a four-year leap rule. A host reaches every field and a configuration byte through a small byte-addressed register bus with single-cycle writes and a combinational read path.

At run time the configuration byte selects how field values appear on the bus: packed BCD or plain binary, and 12-hour or 24-hour hours. A freeze bit stops the strobe from advancing anything, so software can load a new time without a carry landing halfway through the sequence of writes. Strobes that arrive while the block is frozen are discarded. A busy flag, on a pin and in a status byte, is high in exactly the cycle whose closing edge advances the counters.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 1, day of month 1, month 1, year 0, and the configuration byte at 0x0B reads 0x02 (BCD, 24-hour, not frozen).
- R2: An accepted tick adds one second. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and produce a day carry.
- R3: On a day carry, day of week runs 1..7 and wraps 7 to 1 (1 = Sunday). Day of month wraps to 1 at the end of the month and the month then advances. Month 12 wraps to 1 and the year advances, with year 99 wrapping to 0.
- R4: April, June, September and November have 30 days. February has 29 days when the year value is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R5: Bit 2 of the configuration byte sets the data mode for reads and writes of all time fields. With the bit at 0 the mode is packed BCD (tens in bits 7:4, units in bits 3:0). With the bit at 1 the mode is binary.
- R6: Bit 1 of the configuration byte sets the hour format. With the bit at 1 hours read 0..23. With the bit at 0 hours read 1..12, with bit 7 set for PM, so midnight is 0x12 and noon is 0x92 in BCD. Written hours are decoded with the same rule.
- R7: While bit 7 of the configuration byte is set, ticks do not advance the time and are discarded, not deferred. Host writes still take effect.
- R8: Output `upd_busy` and bit 7 of the status byte at 0x0A are 1 exactly in a cycle with `tick_1hz` high and the freeze bit clear, and 0 otherwise. Bits 6:0 of 0x0A read 0. Writes to 0x0A are ignored.
- R9: The field addresses are seconds 0x00, minutes 0x02, hours 0x04, day of week 0x06, day of month 0x07, month 0x08 and year 0x09. Addresses 0x01, 0x03, 0x05, 0x0C, 0x0D, 0x0E and 0x0F read 0x00, and writes to them are ignored.
- R10: A field written in the same cycle as an accepted tick takes the written value. All other fields advance as though the write had not happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle once-per-second advance strobe |
| bus_wr | input | 1 | Write enable for the addressed byte |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| upd_busy | output | 1 | High in the cycle whose closing edge advances the time |

## Verification
The checker tests four properties on every clock. The busy flag never rises without a tick or while frozen. A frozen block with no write holds all fields. An accepted tick without a write always changes the seconds byte. The status and unused addresses read as required. Month lengths, leap years, the year wrap, BCD and binary encodings, 12-hour PM handling, dropped ticks and write-versus-tick collisions can only be shown by the bench scenarios. In those scenarios a behavioural model predicts every read byte and the busy flag.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
   localparam int FLD_N  = 7;
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HR   = 2;
   localparam int F_WDAY = 3;
   localparam int F_MDAY = 4;
   localparam int F_MON  = 5;
   localparam int F_YR   = 6;

   localparam int A_STAT = 10;
   localparam int A_CFG  = 11;

   localparam int CFG_FREEZE = 7;
   localparam int CFG_BIN    = 2;
   localparam int CFG_H24    = 1;
   localparam logic [7:0] CFG_RST = 8'h02;

   typedef logic [FLD_N-1:0][7:0] rtc_fields_t;

   function automatic int fld_addr(input int idx);
      case (idx)
         F_SEC:   return 0;
         F_MIN:   return 2;
         F_HR:    return 4;
         F_WDAY:  return 6;
         F_MDAY:  return 7;
         F_MON:   return 8;
         default: return 9;
      endcase
   endfunction

   function automatic logic [7:0] fld_rst(input int idx);
      return (idx == F_WDAY || idx == F_MDAY || idx == F_MON) ? 8'd1 : 8'd0;
   endfunction

   function automatic logic [7:0] to_bcd(input logic [7:0] v);
      logic [7:0] t;
      logic [7:0] u;
      t = v / 8'd10;
      u = v % 8'd10;
      return {t[3:0], u[3:0]};
   endfunction

   function automatic logic [7:0] from_bcd(input logic [7:0] d);
      return ({4'd0, d[7:4]} * 8'd10) + {4'd0, d[3:0]};
   endfunction

   function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'd2:                     return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
         8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
         default:                  return 8'd31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_time_chain.sv
`timescale 1ns/1ps
module rtc_time_chain
   import rtc_cal_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [FLD_N-1:0]  fld_ld,
   input  logic [7:0]        fld_val,
   output rtc_fields_t       tm
);
   rtc_fields_t nxt;
   logic c_sec, c_min, c_hr, c_mday, c_mon, day;

   // each carry fires when its field sits at or beyond its last legal value
   always_comb begin
      c_sec  = tm[F_SEC]  >= 8'd59;
      c_min  = tm[F_MIN]  >= 8'd59;
      c_hr   = tm[F_HR]   >= 8'd23;
      c_mday = tm[F_MDAY] >= month_len(tm[F_MON], tm[F_YR]);
      c_mon  = tm[F_MON]  >= 8'd12;
      day    = c_sec & c_min & c_hr;
      nxt    = tm;
      if (adv) begin
         nxt[F_SEC] = c_sec ? 8'd0 : tm[F_SEC] + 8'd1;
         if (c_sec)
            nxt[F_MIN] = c_min ? 8'd0 : tm[F_MIN] + 8'd1;
         if (c_sec && c_min)
            nxt[F_HR] = c_hr ? 8'd0 : tm[F_HR] + 8'd1;
         if (day) begin
            nxt[F_WDAY] = (tm[F_WDAY] >= 8'd7) ? 8'd1 : tm[F_WDAY] + 8'd1;
            nxt[F_MDAY] = c_mday ? 8'd1 : tm[F_MDAY] + 8'd1;
         end
         if (day && c_mday)
            nxt[F_MON] = c_mon ? 8'd1 : tm[F_MON] + 8'd1;
         if (day && c_mday && c_mon)
            nxt[F_YR] = (tm[F_YR] >= 8'd99) ? 8'd0 : tm[F_YR] + 8'd1;
      end
   end

   // one register per field; a host load overrides that field only
   for (genvar i = 0; i < FLD_N; i++) begin : g_fld
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tm[i] <= fld_rst(i);
         else if (fld_ld[i])
            tm[i] <= fld_val;
         else
            tm[i] <= nxt[i];
      end
   end
endmodule

// File: rtl/rtc_host_port.sv
`timescale 1ns/1ps
module rtc_host_port
   import rtc_cal_pkg::*;
#(
   parameter int ADDR_W = 4
)(
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic [7:0]        cfg,
   input  logic              busy,
   input  rtc_fields_t       tm,
   output logic [7:0]        rdata,
   output logic [FLD_N-1:0]  fld_ld,
   output logic [7:0]        fld_val,
   output logic              cfg_we
);
   logic             bin_mode, h24;
   logic [FLD_N-1:0] hit;
   logic [7:0]       hr_pm_adj, hr_wr, hr_rd, gen_wr, h12;
   logic [7:0]       h12_raw;

   assign bin_mode = cfg[CFG_BIN];
   assign h24      = cfg[CFG_H24];

   for (genvar i = 0; i < FLD_N; i++) begin : g_dec
      assign hit[i]    = (bus_addr == ADDR_W'(fld_addr(i)));
      assign fld_ld[i] = bus_wr & hit[i];
   end
   assign cfg_we = bus_wr && (bus_addr == ADDR_W'(A_CFG));

   // write side: bus byte to internal binary value
   always_comb begin
      gen_wr  = bin_mode ? bus_wdata : from_bcd(bus_wdata);
      h12_raw = bin_mode ? {1'b0, bus_wdata[6:0]} : from_bcd({1'b0, bus_wdata[6:0]});
      hr_pm_adj = (h12_raw == 8'd12) ? 8'd0 : h12_raw;
      hr_wr   = h24 ? gen_wr : hr_pm_adj + (bus_wdata[7] ? 8'd12 : 8'd0);
      fld_val = hit[F_HR] ? hr_wr : gen_wr;
   end

   // read side: internal binary value to bus byte
   always_comb begin
      h12 = (tm[F_HR] >= 8'd12) ? tm[F_HR] - 8'd12 : tm[F_HR];
      if (h12 == 8'd0)
         h12 = 8'd12;
      if (h24)
         hr_rd = bin_mode ? tm[F_HR] : to_bcd(tm[F_HR]);
      else begin
         hr_rd      = bin_mode ? h12 : to_bcd(h12);
         hr_rd[7]   = (tm[F_HR] >= 8'd12);
      end
      rdata = 8'h00;
      for (int i = 0; i < FLD_N; i++)
         if (hit[i])
            rdata = (i == F_HR) ? hr_rd : (bin_mode ? tm[i] : to_bcd(tm[i]));
      if (bus_addr == ADDR_W'(A_STAT))
         rdata = {busy, 7'd0};
      if (bus_addr == ADDR_W'(A_CFG))
         rdata = cfg;
   end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
   import rtc_cal_pkg::*;
#(
   parameter int ADDR_W = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              upd_busy
);
   logic [7:0]       cfg_q;
   logic             cfg_we;
   logic [FLD_N-1:0] fld_ld;
   logic [7:0]       fld_val;
   rtc_fields_t      tm;

   if (ADDR_W < 4) begin : g_addr_bad
      $error("rtc_calendar: ADDR_W must reach address 0x0D");
   end

   // a tick is taken only when not frozen; otherwise it is lost
   assign upd_busy = tick_1hz & ~cfg_q[CFG_FREEZE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= CFG_RST;
      else if (cfg_we)
         cfg_q <= bus_wdata;
   end

   rtc_host_port #(.ADDR_W(ADDR_W)) u_port (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .cfg      (cfg_q),
      .busy     (upd_busy),
      .tm       (tm),
      .rdata    (bus_rdata),
      .fld_ld   (fld_ld),
      .fld_val  (fld_val),
      .cfg_we   (cfg_we)
   );

   rtc_time_chain u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (upd_busy),
      .fld_ld (fld_ld),
      .fld_val(fld_val),
      .tm     (tm)
   );
endmodule

// File: rtl/rtc_calendar_chk.sv
`timescale 1ns/1ps
module rtc_calendar_chk
   import rtc_cal_pkg::*;
#(
   parameter int ADDR_W = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_rdata,
   input logic              upd_busy,
   input logic              freeze,
   input rtc_fields_t       tm
);
   // R8
   busy_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |-> !upd_busy);

   // R7
   busy_not_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |-> !upd_busy);

   // R7
   frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !bus_wr) |=> $stable(tm));

   // R2
   sec_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_busy && !bus_wr) |=> (tm[F_SEC] != $past(tm[F_SEC])));

   // R8
   stat_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(A_STAT)) |-> (bus_rdata == {upd_busy, 7'd0}));

   // R9
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(1) || bus_addr == ADDR_W'(3) || bus_addr == ADDR_W'(5) ||
       bus_addr == ADDR_W'(12) || bus_addr == ADDR_W'(13)) |-> (bus_rdata == 8'h00));
endmodule

bind rtc_calendar rtc_calendar_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick_1hz),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_rdata(bus_rdata),
   .upd_busy (upd_busy),
   .freeze   (cfg_q[7]),
   .tm       (tm)
);

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = 4'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       upd_busy;

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // model state: 0 sec,1 min,2 hour(0..23),3 wday,4 mday,5 mon,6 year
   int m_t[7];
   int m_cfg;

   always #2.5 clk = ~clk;

   rtc_calendar #(.ADDR_W(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .upd_busy(upd_busy)
   );

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got 0x%0h expected 0x%0h (addr %0d, t=%0t)", tag, got, exp, bus_addr, $time);
      end
   endtask

   function automatic int m_enc(input int v);
      return m_cfg[2] ? v : (((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int m_dec(input int d);
      return m_cfg[2] ? d : (((d >> 4) & 15) * 10 + (d & 15));
   endfunction

   function automatic int m_dim(input int mon, input int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   function automatic int m_idx(input int a);
      case (a)
         0: return 0;
         2: return 1;
         4: return 2;
         6: return 3;
         7: return 4;
         8: return 5;
         9: return 6;
         default: return -1;
      endcase
   endfunction

   function automatic int m_read(input int a, input bit busy);
      int idx, h;
      idx = m_idx(a);
      if (idx == 2) begin
         if (m_cfg[1]) return m_enc(m_t[2]);
         h = m_t[2] % 12;
         if (h == 0) h = 12;
         return m_enc(h) | ((m_t[2] >= 12) ? 8'h80 : 0);
      end
      if (idx >= 0) return m_enc(m_t[idx]);
      if (a == 10) return busy ? 8'h80 : 0;
      if (a == 11) return m_cfg;
      return 0;
   endfunction

   function automatic int m_hr_wr(input int d);
      int h;
      if (m_cfg[1]) return m_dec(d);
      h = m_dec(d & 8'h7F);
      if (h == 12) h = 0;
      return h + ((d & 8'h80) != 0 ? 12 : 0);
   endfunction

   // behavioural reference, advanced on every rising edge
   always @(posedge clk) begin
      int n[7];
      int idx;
      cycles++;
      if (!rst_n) begin
         m_t = '{0, 0, 0, 1, 1, 1, 0};
         m_cfg = 8'h02;
      end else begin
         n = m_t;
         if (tick_1hz && !m_cfg[7]) begin
            n[0] = m_t[0] + 1;
            if (n[0] >= 60) begin
               n[0] = 0; n[1] = m_t[1] + 1;
               if (n[1] >= 60) begin
                  n[1] = 0; n[2] = m_t[2] + 1;
                  if (n[2] >= 24) begin
                     n[2] = 0;
                     n[3] = (m_t[3] >= 7) ? 1 : m_t[3] + 1;
                     if (m_t[4] >= m_dim(m_t[5], m_t[6])) begin
                        n[4] = 1;
                        n[5] = (m_t[5] >= 12) ? 1 : m_t[5] + 1;
                        if (m_t[5] >= 12) n[6] = (m_t[6] >= 99) ? 0 : m_t[6] + 1;
                     end else n[4] = m_t[4] + 1;
                  end
               end
            end
         end
         if (bus_wr) begin
            idx = m_idx(int'(bus_addr));
            if (idx == 2) n[2] = m_hr_wr(int'(bus_wdata));
            else if (idx >= 0) n[idx] = m_dec(int'(bus_wdata));
         end
         m_t = n;
         if (bus_wr && bus_addr == 4'd11) m_cfg = int'(bus_wdata);
      end
   end

   // compare on every clock, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, int'(bus_rdata), m_read(int'(bus_addr), tick_1hz && !m_cfg[7]));
         chk("R8", int'(upd_busy), (tick_1hz && !m_cfg[7]) ? 1 : 0);
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input int a, input int d);
      step();
      bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 8'(d);
      step();
      bus_wr = 1'b0;
   endtask

   task automatic tick();
      step();
      tick_1hz = 1'b1;
      step();
      tick_1hz = 1'b0;
   endtask

   task automatic sweep(input string tag);
      cur_req = tag;
      for (int a = 0; a < 16; a++) begin
         step();
         bus_addr = 4'(a);
      end
      step();
   endtask

   task automatic rd_chk(input int a, input int exp, input string tag);
      step();
      bus_addr = 4'(a);
      @(negedge clk);
      #0.1;
      chk(tag, int'(bus_rdata), exp);
   endtask

   task automatic set_end_of_day(input int mday, input int mon, input int yr);
      wr(7, mday); wr(8, mon); wr(9, yr);
      wr(4, 8'h23); wr(2, 8'h59); wr(0, 8'h59);
   endtask

   initial begin
      fork
         begin
            repeat (100000) @(posedge clk);
            if (!done) begin
               errors++; checks++;
               $display("FAIL watchdog expired after %0d cycles", cycles);
               done = 1'b1;
               $display("  CHECKS %0d ERRORS %0d", checks, errors);
               $finish;
            end
         end
      join_none

      repeat (3) step();
      rst_n = 1'b1;

      // R1 reset contents
      sweep("R1");
      rd_chk(11, 8'h02, "R1");
      rd_chk(7, 8'h01, "R1");

      // R2 and R3: full rollover at the end of a century
      cur_req = "R2";
      wr(6, 7);
      set_end_of_day(8'h31, 8'h12, 8'h99);
      wr(0, 8'h58);
      tick();
      rd_chk(0, 8'h59, "R2");
      tick();
      sweep("R3");
      rd_chk(6, 1, "R3");
      rd_chk(9, 8'h00, "R3");
      rd_chk(8, 8'h01, "R3");

      // R4 month lengths and leap rule
      cur_req = "R4";
      set_end_of_day(8'h28, 8'h02, 8'h24); tick();
      rd_chk(7, 8'h29, "R4");
      set_end_of_day(8'h29, 8'h02, 8'h24); tick();
      rd_chk(8, 8'h03, "R4");
      set_end_of_day(8'h28, 8'h02, 8'h23); tick();
      rd_chk(7, 8'h01, "R4");
      set_end_of_day(8'h30, 8'h04, 8'h23); tick();
      rd_chk(8, 8'h05, "R4");
      set_end_of_day(8'h30, 8'h01, 8'h23); tick();
      rd_chk(7, 8'h31, "R4");
      sweep("R4");

      // R5 binary data mode
      cur_req = "R5";
      wr(11, 8'h06);
      rd_chk(7, 31, "R5");
      wr(0, 59); wr(2, 59); wr(4, 23);
      tick();
      rd_chk(7, 1, "R5");
      rd_chk(8, 2, "R5");
      wr(9, 45);
      rd_chk(9, 45, "R5");
      sweep("R5");
      wr(11, 8'h02);
      rd_chk(9, 8'h45, "R5");

      // R6 twelve-hour format
      cur_req = "R6";
      wr(11, 8'h00);
      wr(4, 8'h91); wr(2, 8'h59); wr(0, 8'h59);
      tick();
      rd_chk(4, 8'h12, "R6");
      wr(4, 8'h11); wr(2, 8'h59); wr(0, 8'h59);
      tick();
      rd_chk(4, 8'h92, "R6");
      sweep("R6");
      wr(11, 8'h02);
      rd_chk(4, 8'h12, "R6");

      // R7 freeze drops ticks but accepts writes
      cur_req = "R7";
      wr(0, 8'h05);
      wr(11, 8'h82);
      bus_addr = 4'd0;
      repeat (4) tick();
      rd_chk(0, 8'h05, "R7");
      wr(0, 8'h10);
      rd_chk(0, 8'h10, "R7");
      wr(11, 8'h02);
      rd_chk(0, 8'h10, "R7");
      tick();
      rd_chk(0, 8'h11, "R7");

      // R8 status byte
      cur_req = "R8";
      bus_addr = 4'd10;
      tick();
      wr(10, 8'hFF);
      rd_chk(10, 8'h00, "R8");
      rd_chk(11, 8'h02, "R8");

      // R9 unused addresses
      cur_req = "R9";
      foreach (m_t[k]) begin end
      wr(1, 8'hFF); wr(3, 8'hFF); wr(5, 8'hFF);
      wr(12, 8'hFF); wr(13, 8'hFF); wr(14, 8'hFF); wr(15, 8'hFF);
      sweep("R9");
      rd_chk(13, 8'h00, "R9");

      // R10 write colliding with an accepted tick
      cur_req = "R10";
      wr(2, 8'h10); wr(0, 8'h59);
      step();
      tick_1hz = 1'b1; bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 8'h30;
      step();
      tick_1hz = 1'b0; bus_wr = 1'b0;
      rd_chk(0, 8'h30, "R10");
      rd_chk(2, 8'h11, "R10");

      step();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule